// File: doc/BRIEF.md
# Selectable-Period Edge-Kicked Watchdog

This block is a watchdog timer for a supervisor device. A host proves it is alive by driving a falling edge on a line that also serves as the chip select of the serial port. The kick line is synchronized and filtered for a minimum pulse width. Each accepted falling edge restarts the period count. If a full period passes without an accepted restart, the block emits a one-cycle timeout pulse, which the reset sequencer turns into a held reset.

A 2-bit selector, kept in nonvolatile storage elsewhere, chooses a long, medium or short period, or turns the timer off. A newly written selector does not act at once. It is copied into the active setting only when the sequencer pulses an apply strobe, at the end of the next read or write command or at power-up. While the sequencer holds the system in reset it raises a hold-off flag. The count stays at zero during hold-off and starts again from zero when the flag drops. Period lengths and the minimum kick width are parameters in clock cycles.

Top module: `kick_watchdog`

## Requirements
- R1: The active selector encodes the period as 2'b00 = P_LONG cycles, 2'b01 = P_MID cycles, 2'b10 = P_SHORT cycles and 2'b11 = disabled.
- R2: With no accepted kick, `timeout_o` pulses high for exactly one cycle once a full period has elapsed, measured from the last restart. The count then starts over, so the pulse repeats every period.
- R3: Only an accepted high-to-low transition of `kick_in` restarts the count. A line held steadily high, or steadily low, still times out.
- R4: A new level on `kick_in` is accepted only after it has been seen for MIN_PULSE consecutive cycles at the output of a SYNC_STAGES flop synchronizer. A low pulse shorter than that does not restart the count.
- R5: A value on `cfg_sel_i` is adopted only at a clock edge where `cfg_apply_i` is high. Until then the previous active setting stays in force.
- R6: While `rst_hold_i` is high the count is held at zero and no pulse is produced. After the flag falls, the first pulse appears on the edge that completes a full period from the release edge.
- R7: While the timer is disabled the count stays at zero and no pulse is produced. Enabling the timer starts a fresh full period, so the first pulse follows the apply edge by exactly the selected number of cycles.
- R8: If a shorter period is applied while the count is already past the new limit, the timer expires on the next clock edge.
- R9: After `rst_n` the active setting is disabled (2'b11), the kick line is taken as idle high, and `timeout_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| kick_in | input | 1 | Asynchronous chip-select/kick line; an accepted falling edge restarts the timer |
| cfg_sel_i | input | 2 | Period selector from the status register (see R1) |
| cfg_apply_i | input | 1 | Strobe that copies `cfg_sel_i` into the active setting |
| rst_hold_i | input | 1 | High while the system reset is active; holds the count at zero |
| timeout_o | output | 1 | One-cycle timeout pulse to the reset sequencer |

## Verification
The assertions assume that every period parameter is at least 2 cycles. They also assume that the reset sequencer keeps the apply strobe and the hold-off flag synchronous to `clk`, while `kick_in` alone may change at any time. The bench drives every input on the falling clock edge. Each kick low phase is either clearly longer than MIN_PULSE or clearly shorter, and each kick period is kept far from the selected limit, so that only the intended outcome is possible. The hold-off and apply sequences are placed so that the first-pulse timing in R6, R7 and R8 can be counted to the exact cycle.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  // Period selector values; the encoding is fixed by the status register.
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/kwd_kick_filter.sv
`timescale 1ns/1ps
module kwd_kick_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_in,
  output logic kick_o
);
  localparam int RW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(MIN_PULSE - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   sync_lvl;
  logic                   lvl_q, lvl_d;
  logic [RW-1:0]          run_q, run_d;

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one_stage
      assign sync_d = kick_in;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], kick_in};
    end
  endgenerate

  // Width filter: a differing level must persist MIN_PULSE cycles.
  always_comb begin
    lvl_d  = lvl_q;
    run_d  = '0;
    kick_o = 1'b0;
    if (sync_lvl != lvl_q) begin
      if (run_q == RUN_LAST) begin
        lvl_d  = sync_lvl;
        kick_o = ~sync_lvl;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      lvl_q  <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= sync_d;
      lvl_q  <= lvl_d;
      run_q  <= run_d;
    end
  end

  // R3: an accepted kick leaves the filtered line low
  p_kick_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |=> !lvl_q);
  // R4: the filtered level never moves while the synchronized input agrees
  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/kwd_cfg_latch.sv
`timescale 1ns/1ps
module kwd_cfg_latch
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_sel_i,
  input  logic       cfg_apply_i,
  output wd_sel_e    sel_o
);
  wd_sel_e sel_q, sel_d;

  always_comb begin
    sel_d = wd_sel_e'(cfg_sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_OFF;
    end else if (cfg_apply_i) begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  // R5: the active setting moves only on an apply strobe
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_apply_i |=> $stable(sel_q));
endmodule

// File: rtl/kwd_timer.sv
`timescale 1ns/1ps
module kwd_timer
  import kwd_pkg::*;
#(
  parameter int P_LONG  = 70_000_000,
  parameter int P_MID   = 30_000_000,
  parameter int P_SHORT = 10_000_000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wd_sel_e sel_i,
  input  logic    kick_i,
  input  logic    hold_i,
  output logic    expire_o
);
  localparam int P_MAX = (P_LONG > P_MID) ? ((P_LONG > P_SHORT) ? P_LONG : P_SHORT)
                                          : ((P_MID > P_SHORT) ? P_MID : P_SHORT);
  localparam int CW = $clog2(P_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          exp_q, exp_d;
  logic          idle;

  always_comb begin
    case (sel_i)
      SEL_LONG:  last = CW'(P_LONG - 1);
      SEL_MID:   last = CW'(P_MID - 1);
      SEL_SHORT: last = CW'(P_SHORT - 1);
      default:   last = '0;
    endcase
  end

  assign idle = hold_i || (sel_i == SEL_OFF);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    exp_d = 1'b0;
    if (idle || kick_i) begin
      cnt_d = '0;
    end else if (cnt_q >= last) begin
      cnt_d = '0;
      exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;

  // R2: the timeout pulse lasts one cycle
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);
  // R3: a kick clears the count and suppresses expiry
  p_kick_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0) && !exp_q);
  // R6: hold-off keeps the timer quiet
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0) && !exp_q);
  // R7: a disabled timer stays at zero without pulses
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_OFF) |=> (cnt_q == '0) && !exp_q);
  // R8: a count beyond the current limit wraps on the next edge
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > last) |=> (cnt_q == '0));
endmodule

// File: rtl/kick_watchdog.sv
`timescale 1ns/1ps
module kick_watchdog
  import kwd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 20,
  parameter int P_LONG      = 70_000_000,
  parameter int P_MID       = 30_000_000,
  parameter int P_SHORT     = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_in,
  input  logic [1:0] cfg_sel_i,
  input  logic       cfg_apply_i,
  input  logic       rst_hold_i,
  output logic       timeout_o
);
  logic    kick_acc;
  wd_sel_e sel_act;

  kwd_kick_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_PULSE   (MIN_PULSE)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick_in (kick_in),
    .kick_o  (kick_acc)
  );

  kwd_cfg_latch u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_apply_i (cfg_apply_i),
    .sel_o       (sel_act)
  );

  kwd_timer #(
    .P_LONG  (P_LONG),
    .P_MID   (P_MID),
    .P_SHORT (P_SHORT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_act),
    .kick_i   (kick_acc),
    .hold_i   (rst_hold_i),
    .expire_o (timeout_o)
  );
endmodule

// File: tb/kick_watchdog_bench.sv
`timescale 1ns/1ps
module kick_watchdog_bench;
  localparam int SYNC  = 2;
  localparam int MINP  = 4;
  localparam int PL    = 200;
  localparam int PM    = 100;
  localparam int PS    = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       kick_in;
  logic [1:0] cfg_sel;
  logic       cfg_apply;
  logic       rst_hold;
  logic       timeout_o;

  int    checks = 0;
  int    errors = 0;
  int    dut_pulses = 0;
  int    mod_pulses = 0;
  int    double_pulses = 0;
  bit    prev_to = 1'b0;
  bit    model_live = 1'b0;
  string cur_req = "R9";

  always #10 clk = ~clk;  // 50 MHz

  kick_watchdog #(
    .SYNC_STAGES (SYNC),
    .MIN_PULSE   (MINP),
    .P_LONG      (PL),
    .P_MID       (PM),
    .P_SHORT     (PS)
  ) u_kick_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_in     (kick_in),
    .cfg_sel_i   (cfg_sel),
    .cfg_apply_i (cfg_apply),
    .rst_hold_i  (rst_hold),
    .timeout_o   (timeout_o)
  );

  // Behavioural reference: input history queue, integer counters.
  bit   hist[$];
  bit   m_lvl;
  int   m_run;
  int   m_cnt;
  int   m_act;
  bit   m_to;

  function automatic int period_of(int s);
    case (s)
      0: return PL;
      1: return PM;
      2: return PS;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit seen;
    bit accepted;
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < SYNC; i++) hist.push_back(1'b1);
      m_lvl = 1'b1; m_run = 0; m_cnt = 0; m_act = 3; m_to = 1'b0;
      model_live = 1'b1;
    end else begin
      seen = hist[0];
      accepted = 1'b0;
      if (seen != m_lvl) begin
        if (m_run == MINP - 1) begin
          m_lvl = seen; m_run = 0; accepted = !seen;
        end else m_run++;
      end else m_run = 0;
      void'(hist.pop_front());
      hist.push_back(kick_in);
      m_to = 1'b0;
      if (rst_hold || m_act == 3 || accepted) m_cnt = 0;
      else if (m_cnt >= period_of(m_act) - 1) begin m_cnt = 0; m_to = 1'b1; end
      else m_cnt++;
      if (cfg_apply) m_act = cfg_sel;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_live) begin
      checks++;
      if (timeout_o !== m_to) begin
        errors++;
        $display("FAIL %s per-cycle timeout actual=%0b expected=%0b at %0t", cur_req, timeout_o, m_to, $time);
      end
      if (timeout_o) dut_pulses++;
      if (m_to) mod_pulses++;
      if (timeout_o && prev_to) double_pulses++;
      prev_to = timeout_o;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    #1; dut_pulses = 0; mod_pulses = 0;
  endtask

  task automatic apply(logic [1:0] v);
    cfg_sel = v; cfg_apply = 1'b1;
    tick(1);
    cfg_apply = 1'b0;
  endtask

  task automatic kick_train(int period, int low_len, int total);
    for (int t = 0; t < total; t += period) begin
      kick_in = 1'b0; tick(low_len);
      kick_in = 1'b1; tick(period - low_len);
    end
  endtask

  task automatic run_all();
    rst_n = 1'b0; kick_in = 1'b1; cfg_sel = 2'b11; cfg_apply = 1'b0; rst_hold = 1'b0;
    tick(5);
    rst_n = 1'b1;
    #1;
    check(timeout_o == 1'b0, "R9 reset output", timeout_o, 0);

    cur_req = "R1"; clear_counts();
    tick(300); #1;
    check(dut_pulses == 0, "R1 disabled after reset", dut_pulses, 0);

    cur_req = "R2"; clear_counts();
    apply(2'b10); tick(200); #1;
    check(dut_pulses == 5, "R2 short period pulses", dut_pulses, 5);
    check(double_pulses == 0, "R2 single-cycle pulse", double_pulses, 0);

    cur_req = "R3"; clear_counts();
    kick_train(30, 8, 300); #1;
    check(dut_pulses == 0, "R3 falling edges restart", dut_pulses, 0);
    clear_counts();
    kick_in = 1'b0; tick(200); #1;
    check(dut_pulses > 0, "R3 steady low times out", dut_pulses, 4);
    kick_in = 1'b1; tick(20);

    cur_req = "R4"; clear_counts();
    kick_train(30, 2, 300); #1;
    check(dut_pulses > 0, "R4 short pulses ignored", dut_pulses, 7);

    cur_req = "R5"; clear_counts();
    cfg_sel = 2'b00;
    kick_train(60, 8, 300); #1;
    check(dut_pulses > 0, "R5 old short setting still in force", dut_pulses, 5);
    apply(2'b00); clear_counts();
    kick_train(60, 8, 420); #1;
    check(dut_pulses == 0, "R5 long setting after apply", dut_pulses, 0);

    cur_req = "R8"; kick_train(20, 8, 20); tick(150); clear_counts();
    check(dut_pulses == 0, "R8 no pulse before shortening", dut_pulses, 0);
    apply(2'b10); tick(2); #1;
    check(dut_pulses == 1, "R8 expiry right after shortening", dut_pulses, 1);

    cur_req = "R6"; rst_hold = 1'b1; clear_counts();
    tick(300); #1;
    check(dut_pulses == 0, "R6 quiet during hold", dut_pulses, 0);
    rst_hold = 1'b0; clear_counts();
    tick(39); #1;
    check(dut_pulses == 0, "R6 no pulse before full period", dut_pulses, 0);
    tick(1); #1;
    check(dut_pulses == 1, "R6 first pulse one period after release", dut_pulses, 1);

    cur_req = "R7"; apply(2'b11); clear_counts();
    tick(400); #1;
    check(dut_pulses == 0, "R7 disabled quiet", dut_pulses, 0);
    apply(2'b10); clear_counts();
    tick(39); #1;
    check(dut_pulses == 0, "R7 fresh period start", dut_pulses, 0);
    tick(1); #1;
    check(dut_pulses == 1, "R7 first pulse after enable", dut_pulses, 1);

    cur_req = "R1"; apply(2'b01); clear_counts();
    kick_train(80, 8, 400); #1;
    check(dut_pulses == 0, "R1 medium period kicked in time", dut_pulses, 0);
    clear_counts();
    kick_train(120, 8, 480); #1;
    check(dut_pulses > 0, "R1 medium period kicked too late", dut_pulses, 4);
    check(dut_pulses == mod_pulses, "R1 pulse count vs model", dut_pulses, mod_pulses);
    check(double_pulses == 0, "R2 no back-to-back pulses overall", double_pulses, 0);
  endtask

  initial begin
    fork
      begin run_all(); end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule